// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles. It uses one adder that is as wide as an operand, and it does not build a full array multiplier. A one-cycle `start` pulse captures the multiplicand into a fixed register. The same pulse loads the multiplier into the lower half of a double-width accumulator and clears the upper half of that accumulator.

Every cycle after that performs one iteration. The block tests the lowest accumulator bit. If that bit is set, the block adds the multiplicand to the upper half. It then shifts the whole accumulator right by one place. The carry out of the add becomes the new top bit, so no part of the sum is lost.

After exactly `W` iterations the accumulator holds the full `2*W`-bit product. The block presents this product as two halves, `hi` and `lo`, and raises `done`. The result stays on the outputs until the next accepted start. A client raises `start` when `busy` is low, either from idle or while a previous result is shown, and then waits for `done`.

Top module: `seq_shift_mul`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy` and `done` are 0 and `hi` and `lo` are 0.
- R2: When `start` is high at a clock edge with `busy` low, `busy` is 1 and `done` is 0 from the following cycle on.
- R3: After an accepted start, `busy` stays high for exactly `W` cycles (32 by default). In the cycle after the last of them, `done` is 1 and `busy` is 0.
- R4: When `done` rises, `{hi, lo}` equals the unsigned product of the multiplicand and multiplier values that were present at the accepted start. `hi` holds bits 2W-1..W and `lo` holds bits W-1..0. This holds for all-ones operands, where the product needs the carry of every add.
- R5: While `done` is high and no start is applied, `hi`, `lo` and `done` do not change.
- R6: A `start` that is high while `busy` is high is ignored. The running operation completes at its original time with its original result.
- R7: `busy` and `done` are never high in the same cycle.
- R8: Changes on the operand inputs after the accepted start have no effect on the result. A zero operand gives a zero product.
- R9: A start applied while `done` is high is accepted. It clears `done`, and the new result follows the timing of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new multiply; honoured only when `busy` is low |
| multiplicand | input | W | Multiplicand operand, captured on an accepted start |
| multiplier | input | W | Multiplier operand, captured on an accepted start |
| busy | output | 1 | An iteration sequence is running |
| done | output | 1 | `hi`/`lo` hold a finished product |
| hi | output | W | Upper half of the product |
| lo | output | W | Lower half of the product |

## Verification
The assertions assume that `rst_n` is low at time zero. They also assume that `start` and the operands are known values once reset is released. The timing properties count busy cycles from the edge where `start` was taken, so they take for granted that `start` is sampled only on rising edges. The stimulus changes every input on the falling clock edge, so it never races the sampling edge. The stimulus also deliberately raises `start` and changes operands while a multiply runs, but only in ways the requirements say must be ignored.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

endpackage

// File: rtl/shmul_adder.sv
module shmul_adder #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] carry;
            assign carry[0] = 1'b0;
            for (genvar i = 0; i < W; i++) begin : g_bit
                logic p;
                assign p          = a[i] ^ b[i];
                assign sum[i]     = p ^ carry[i];
                assign carry[i+1] = (a[i] & b[i]) | (p & carry[i]);
            end
            assign sum[W] = carry[W];
        end else begin : g_behav
            assign sum = {1'b0, a} + {1'b0, b};
        end
    endgenerate

endmodule

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
    import shmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        mul_state_e       st;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        load   = 1'b0;
        step   = 1'b0;
        case (ctrl_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    load       = 1'b1;
                    ctrl_d.st  = ST_RUN;
                    ctrl_d.cnt = '0;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (ctrl_q.cnt == LAST) begin
                    ctrl_d.st = ST_DONE;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st  <= ST_IDLE;
            ctrl_q.cnt <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy = (ctrl_q.st == ST_RUN);
    assign done = (ctrl_q.st == ST_DONE);

endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    output logic [W-1:0] upper,
    output logic [W-1:0] lower
);

    localparam int PW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  mcand;
        logic [PW-1:0] acc;
    } dp_t;

    dp_t dp_d, dp_q;

    logic [W-1:0] addend;
    logic [W:0]   part_sum;

    assign addend = dp_q.acc[0] ? dp_q.mcand : '0;

    shmul_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
        .a   (dp_q.acc[PW-1:W]),
        .b   (addend),
        .sum (part_sum)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.mcand = mcand_in;
            dp_d.acc   = {{W{1'b0}}, mplier_in};
        end else if (step) begin
            dp_d.acc = {part_sum, dp_q.acc[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign upper = dp_q.acc[PW-1:W];
    assign lower = dp_q.acc[W-1:0];

endmodule

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] multiplicand,
    input  logic [W-1:0] multiplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    logic load;
    logic step;

    shmul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    shmul_datapath #(.W(W), .RIPPLE(RIPPLE)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .upper     (hi),
        .lower     (lo)
    );

endmodule

// File: rtl/shmul_chk.sv
module shmul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);

    localparam int CW = $clog2(W + 1) + 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!busy) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R7
    excl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R3
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt == LAST) |=> (done && !busy));

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt != LAST) |=> busy);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(hi) && $stable(lo)));

endmodule

bind seq_shift_mul shmul_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo)
);

// File: tb/seq_shift_mul_tb.sv
`timescale 1ns/1ps
module seq_shift_mul_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] multiplicand = '0;
    logic [W-1:0] multiplier = '0;
    logic         busy, done;
    logic [W-1:0] hi, lo;

    int checks = 0;
    int failures = 0;
    logic [2*W-1:0] exp_q[$];
    logic done_prev = 1'b0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_shift_mul #(.W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .busy         (busy),
        .done         (done),
        .hi           (hi),
        .lo           (lo)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: compare each completed product against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done && !done_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected result", {hi, lo}, '0);
            end else begin
                logic [2*W-1:0] e;
                e = exp_q.pop_front();
                chk({hi, lo} === e, "R4 product", {hi, lo}, e);
            end
        end
        done_prev = done;
    end

    // Driver: launch one multiply, optionally disturbing inputs while busy
    task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit disturb);
        int n;
        multiplicand = a;
        multiplier   = b;
        start        = 1'b1;
        exp_q.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R2 busy after start", {62'b0, busy, done}, 64'd2);
        n = 0;
        while (busy && n < 1000) begin
            chk(!done, "R7 busy with done", {63'b0, done}, 64'd0);
            if (disturb) begin
                // R6 / R8: a start and new operands during the run
                if (n == 5) begin
                    start        = 1'b1;
                    multiplicand = ~a;
                    multiplier   = b + 1;
                end else if (n == 6) begin
                    start = 1'b0;
                end
            end
            n++;
            @(negedge clk);
        end
        chk(n == W, "R3 busy cycle count", 64'(n), 64'(W));
        chk(done && !busy, "R3 done after run", {62'b0, busy, done}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(!busy && !done && {hi, lo} == '0, "R1 reset state",
            {busy, done, hi[W-3:0], lo}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && {hi, lo} == '0, "R1 after release",
            {busy, done, hi[W-3:0], lo}, '0);

        do_mul(32'd6, 32'd3, 1'b0);
        do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);   // R4 carry at every add
        do_mul(32'h0, 32'hDEAD_BEEF, 1'b0);           // R8 zero multiplicand
        do_mul(32'h1234_5678, 32'h0, 1'b0);           // R8 zero multiplier
        do_mul(32'h8000_0000, 32'h8000_0000, 1'b0);
        do_mul(32'hCAFE_F00D, 32'h0000_0001, 1'b0);

        // R5: result held while done and no start
        begin
            logic [2*W-1:0] held;
            held = {hi, lo};
            repeat (6) @(negedge clk);
            chk(done && {hi, lo} === held, "R5 result held", {hi, lo}, held);
        end

        // R6 and R8: disturbed run keeps original result and timing
        do_mul(32'h89AB_CDEF, 32'h7654_3210, 1'b1);

        // R9: back-to-back starts directly from done
        for (int i = 0; i < 6; i++) begin
            do_mul($urandom, $urandom, 1'b0);
        end

        @(negedge clk);
        chk(exp_q.size() == 0, "R4 all results seen", 64'(exp_q.size()), 64'd0);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        report();
    end

endmodule